// File: doc/BRIEF.md
# Parallel Double-Error Locator

This block finds the bit positions of up to two errors in a 79-bit shortened binary BCH word over GF(2^7), the double-error-correcting, triple-error-detecting code used to protect 64 data bits in a fast embedded memory. An upstream syndrome generator and error classifier supply the odd-weight syndrome S1, the cubic syndrome S3 and a 2-bit error-count code. The locator turns S1 and S3 straight into the coefficients of a reversed error-locator polynomial and tests all 79 positions at once. The result is an error vector as wide as the word, and the corrected word is the received word XOR that vector.

The syndromes reach the locator through a bank of capture flops. On a capture strobe the received word is always taken. The syndrome pair is loaded only when the classifier reports exactly two errors. For any other count the locator logic keeps its previous inputs, so none of its nodes toggle, and the error vector is forced to zero. The outputs reflect a capture from the cycle after the strobe and hold until the next strobe.

Top module: `dlocx_double_locator`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears its state. After that edge `err_vec` and `fixed_word` are both all zeros.
- R2: A rising edge with `syn_cap` high captures the inputs, and the outputs reflect that capture from just after the edge. On edges where `syn_cap` is low, `err_vec` and `fixed_word` keep their values whatever the other inputs do.
- R3: The count code `err_cnt` is 2'b00 for none, 2'b01 for one, 2'b10 for two and 2'b11 for three errors. Only 2'b10 enables location. After a capture with any other code, `err_vec` is all zeros and `fixed_word` equals the captured `rx_word`.
- R4: The field uses the primitive polynomial x^7+x^3+1 with alpha = 7'h02, and bit i of `err_vec` stands for alpha^i. For every pair of distinct positions j and k in 0..78, capturing code 2'b10 with S1 = alpha^j + alpha^k and S3 = alpha^3j + alpha^3k sets exactly bits j and k.
- R5: A capture with code 2'b10, S1 = alpha^j and S3 = alpha^3j (a single error presented as double) sets exactly bit j, for every j in 0..78.
- R6: A capture with code 2'b10 and S1 = 0 gives an all-zero `err_vec` for any S3, including S3 = 0.
- R7: `fixed_word` always equals the captured `rx_word` XOR `err_vec`.
- R8: For any S1 and S3 captured with code 2'b10, `err_vec` has at most two bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| syn_cap | input | 1 | Capture strobe for word, syndromes and count code |
| err_cnt | input | 2 | Error-count code from the classifier (2'b10 = two errors) |
| syn_s1 | input | 7 | Syndrome S1 |
| syn_s3 | input | 7 | Syndrome S3 |
| rx_word | input | 79 | Received word |
| err_vec | output | 79 | Error positions, bit i = alpha^i |
| fixed_word | output | 79 | Captured word XOR error vector |

## Verification
The bench walks every one of the 3081 position pairs and every single position, each with a fresh random word. A wrong constant multiplier or a wrong alpha power would show up as a missing or misplaced bit in some pair. The S1 = 0 case with S3 = 0 is aimed at a locator that lacks the zero guard, which would light every bit. Non-double count codes and strobe-low cycles with changing inputs target designs that leak syndromes through or fail to hold their outputs. Random syndromes that match no real pattern check that the quadratic never claims more than two roots.

// File: rtl/dlocx_pkg.sv
package dlocx_pkg;

    localparam int GF_M     = 7;
    localparam int GF_ORDER = (1 << GF_M) - 1;
    localparam logic [GF_M:0] GF_POLY = 8'h89;

    typedef logic [GF_M-1:0] gf_t;

    typedef enum logic [1:0] {
        CNT_NONE  = 2'b00,
        CNT_ONE   = 2'b01,
        CNT_TWO   = 2'b10,
        CNT_THREE = 2'b11
    } err_cnt_e;

    typedef struct packed {
        gf_t s1;
        gf_t s3;
    } syn_pair_t;

    typedef struct packed {
        gf_t t0;
        gf_t t1;
        gf_t t2;
    } rlp_coef_t;

    function automatic gf_t gf_xtime(gf_t a);
        gf_t r;
        r = {a[GF_M-2:0], 1'b0};
        if (a[GF_M-1])
            r = r ^ GF_POLY[GF_M-1:0];
        return r;
    endfunction

    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t acc;
        gf_t sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < GF_M; k++) begin
            if (b[k])
                acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    function automatic gf_t gf_alpha_pow(int e);
        gf_t r;
        int  red;
        red = e % GF_ORDER;
        r   = gf_t'(1);
        for (int k = 0; k < red; k++)
            r = gf_xtime(r);
        return r;
    endfunction

endpackage

// File: rtl/dlocx_syn_hold.sv
module dlocx_syn_hold
    import dlocx_pkg::*;
#(
    parameter int N = 79
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  err_cnt_e     cnt,
    input  syn_pair_t    syn_in,
    input  logic [N-1:0] word_in,
    output syn_pair_t    syn_q,
    output logic         arm_q,
    output logic [N-1:0] word_q
);

    logic take_syn;

    assign take_syn = cap && (cnt == CNT_TWO);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            arm_q  <= 1'b0;
        end else if (cap) begin
            word_q <= word_in;
            arm_q  <= (cnt == CNT_TWO);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            syn_q <= '0;
        else if (take_syn)
            syn_q <= syn_in;
    end

endmodule

// File: rtl/dlocx_coef.sv
module dlocx_coef
    import dlocx_pkg::*;
(
    input  syn_pair_t syn,
    output rlp_coef_t coef,
    output logic      s1_nz
);

    gf_t s1_sq;
    gf_t s1_cube;

    always_comb begin
        s1_sq   = gf_mul(syn.s1, syn.s1);
        s1_cube = gf_mul(s1_sq, syn.s1);
        coef.t0 = syn.s1;
        coef.t1 = s1_sq;
        coef.t2 = syn.s3 ^ s1_cube;
        s1_nz   = |syn.s1;
    end

endmodule

// File: rtl/dlocx_chien.sv
module dlocx_chien
    import dlocx_pkg::*;
#(
    parameter int N = 79
) (
    input  rlp_coef_t    coef,
    input  logic         en,
    output logic [N-1:0] hit
);

    for (genvar g = 0; g < N; g++) begin : g_pos
        localparam gf_t A_LIN = gf_alpha_pow(g);
        localparam gf_t A_SQ  = gf_alpha_pow(2 * g);
        gf_t eval;

        always_comb begin
            eval = gf_mul(coef.t0, A_SQ) ^ gf_mul(coef.t1, A_LIN) ^ coef.t2;
        end

        assign hit[g] = en && (eval == '0);
    end

endmodule

// File: rtl/dlocx_double_locator.sv
module dlocx_double_locator
    import dlocx_pkg::*;
#(
    parameter int N = 79
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 syn_cap,
    input  logic [1:0]           err_cnt,
    input  logic [GF_M-1:0]      syn_s1,
    input  logic [GF_M-1:0]      syn_s3,
    input  logic [N-1:0]         rx_word,
    output logic [N-1:0]         err_vec,
    output logic [N-1:0]         fixed_word
);

    syn_pair_t    syn_in;
    syn_pair_t    syn_q;
    logic         arm_q;
    logic [N-1:0] word_q;
    rlp_coef_t    coef;
    logic         s1_nz;
    logic         loc_en;

    assign syn_in.s1 = syn_s1;
    assign syn_in.s3 = syn_s3;

    dlocx_syn_hold #(.N(N)) hold_i (
        .clk     (clk),
        .rst     (rst),
        .cap     (syn_cap),
        .cnt     (err_cnt_e'(err_cnt)),
        .syn_in  (syn_in),
        .word_in (rx_word),
        .syn_q   (syn_q),
        .arm_q   (arm_q),
        .word_q  (word_q)
    );

    dlocx_coef coef_i (
        .syn   (syn_q),
        .coef  (coef),
        .s1_nz (s1_nz)
    );

    assign loc_en = arm_q && s1_nz;

    dlocx_chien #(.N(N)) chien_i (
        .coef (coef),
        .en   (loc_en),
        .hit  (err_vec)
    );

    assign fixed_word = word_q ^ err_vec;

endmodule

// File: rtl/dlocx_double_locator_chk.sv
module dlocx_double_locator_chk
    import dlocx_pkg::*;
#(
    parameter int N = 79
) (
    input logic            clk,
    input logic            rst,
    input logic            syn_cap,
    input logic [1:0]      err_cnt,
    input logic [GF_M-1:0] syn_s1,
    input logic [GF_M-1:0] syn_s3,
    input logic [N-1:0]    rx_word,
    input logic [N-1:0]    err_vec,
    input logic [N-1:0]    fixed_word
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (err_vec == '0 && fixed_word == '0));

    a_r2_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        !syn_cap |=> ($stable(err_vec) && $stable(fixed_word)));

    a_r3_other_codes_quiet: assert property (@(posedge clk) disable iff (rst)
        (syn_cap && err_cnt != 2'b10) |=> (err_vec == '0 && fixed_word == $past(rx_word)));

    a_r6_zero_s1_quiet: assert property (@(posedge clk) disable iff (rst)
        (syn_cap && err_cnt == 2'b10 && syn_s1 == '0) |=> (err_vec == '0));

    a_r7_word_relation: assert property (@(posedge clk) disable iff (rst)
        syn_cap |=> ((fixed_word ^ err_vec) == $past(rx_word)));

    a_r8_at_most_two: assert property (@(posedge clk) disable iff (rst)
        $countones(err_vec) <= 2);

endmodule

bind dlocx_double_locator dlocx_double_locator_chk #(.N(N)) chk_i (.*);

// File: tb/dlocx_double_locator_tb_top.sv
module dlocx_double_locator_tb_top;

    localparam int NB = 79;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          syn_cap = 1'b0;
    logic [1:0]    err_cnt = 2'b00;
    logic [6:0]    syn_s1 = '0;
    logic [6:0]    syn_s3 = '0;
    logic [NB-1:0] rx_word = '0;
    logic [NB-1:0] err_vec;
    logic [NB-1:0] fixed_word;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dlocx_double_locator #(.N(NB)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .syn_cap    (syn_cap),
        .err_cnt    (err_cnt),
        .syn_s1     (syn_s1),
        .syn_s3     (syn_s3),
        .rx_word    (rx_word),
        .err_vec    (err_vec),
        .fixed_word (fixed_word)
    );

    function automatic logic [6:0] tb_apow(int e);
        logic [7:0] v;
        v = 8'h01;
        for (int k = 0; k < (e % 127); k++) begin
            v = v << 1;
            if (v[7]) v = v ^ 8'h89;
        end
        return v[6:0];
    endfunction

    function automatic logic [NB-1:0] rand_word();
        logic [NB-1:0] w;
        w = {$urandom(), $urandom(), $urandom()};
        return w;
    endfunction

    task automatic check(bit ok, string req, logic [NB-1:0] act, logic [NB-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(bit cap, logic [1:0] cnt, logic [6:0] s1, logic [6:0] s3, logic [NB-1:0] w);
        @(negedge clk);
        syn_cap = cap;
        err_cnt = cnt;
        syn_s1  = s1;
        syn_s3  = s3;
        rx_word = w;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 190000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NB-1:0] w;
        logic [NB-1:0] exp;
        logic [NB-1:0] held_e;
        logic [NB-1:0] held_f;
        void'($urandom(32'd4711));

        repeat (3) @(posedge clk);
        #2;
        check(err_vec == '0 && fixed_word == '0, "R1 reset", err_vec, '0);
        @(negedge clk);
        rst = 1'b0;

        // R4 and R7: every pair of distinct positions
        for (int j = 0; j < NB; j++) begin
            for (int k = j + 1; k < NB; k++) begin
                w = rand_word();
                exp = '0;
                exp[j] = 1'b1;
                exp[k] = 1'b1;
                step(1, 2'b10, tb_apow(j) ^ tb_apow(k), tb_apow(3 * j) ^ tb_apow(3 * k), w);
                check(err_vec == exp, "R4 pair", err_vec, exp);
                check(fixed_word == (w ^ exp), "R7 fixed word", fixed_word, w ^ exp);
            end
        end

        // R2: hold while strobe low
        held_e = err_vec;
        held_f = fixed_word;
        for (int r = 0; r < 8; r++) begin
            step(0, 2'($urandom()), 7'($urandom()), 7'($urandom()), rand_word());
            check(err_vec == held_e && fixed_word == held_f, "R2 hold", err_vec, held_e);
        end

        // R5: single errors flagged as double
        for (int j = 0; j < NB; j++) begin
            w = rand_word();
            exp = '0;
            exp[j] = 1'b1;
            step(1, 2'b10, tb_apow(j), tb_apow(3 * j), w);
            check(err_vec == exp, "R5 single", err_vec, exp);
        end

        // R3: other count codes
        for (int c = 0; c < 4; c++) begin
            if (c == 2) continue;
            for (int r = 0; r < 6; r++) begin
                w = rand_word();
                step(1, 2'(c), tb_apow(r) ^ tb_apow(r + 5), tb_apow(3 * r) ^ tb_apow(3 * r + 15), w);
                check(err_vec == '0, "R3 code quiet", err_vec, '0);
                check(fixed_word == w, "R3 word pass", fixed_word, w);
            end
        end

        // R6: S1 zero
        w = rand_word();
        step(1, 2'b10, 7'h00, 7'h00, w);
        check(err_vec == '0, "R6 s1 s3 zero", err_vec, '0);
        for (int r = 0; r < 10; r++) begin
            w = rand_word();
            step(1, 2'b10, 7'h00, 7'($urandom()), w);
            check(err_vec == '0, "R6 s1 zero", err_vec, '0);
        end

        // R8: random syndromes
        for (int r = 0; r < 500; r++) begin
            w = rand_word();
            step(1, 2'b10, 7'($urandom()), 7'($urandom()), w);
            check($countones(err_vec) <= 2, "R8 at most two", err_vec, '0);
            check(fixed_word == (w ^ err_vec), "R7 random", fixed_word, w ^ err_vec);
        end

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check(err_vec == '0 && fixed_word == '0, "R1 reset again", fixed_word, '0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule